// File: doc/BRIEF.md
# Carry-Chained ALU Flag Unit

A word-wide arithmetic and logic datapath paired with a four-bit condition flag register (zero, negative, carry, overflow). It does add-with-carry, subtract-with-borrow, the three bitwise operations, and shifts left, logical right and arithmetic right. The result is combinational from the operands. The flags are the registered state: each operation works out its next flag value from the current flags, and that value is stored on the clock edge when the write enable is high.

The carry-using arithmetic chains the zero flag across words. The new zero flag is the old zero flag ANDed with "this word is zero". A multi-word add or subtract therefore leaves Z set only if every word of the wide result was zero, provided software starts the chain with Z set. Each class of operation writes only its own subset of flags and keeps the others, so a flag produced earlier can survive later bitwise work.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcode 0 (add-with-carry) gives result = a + b + C, where C is the current carry flag, truncated to WIDTH bits.
- R2: Opcode 1 (subtract-with-borrow) gives result = b - a - C. The second operand b is the minuend.
- R3: For opcodes 0 and 1 the new Z is the old Z AND (result == 0). A zero result never sets a Z that was clear.
- R4: Every flag write sets N to the most significant bit of the result.
- R5: For opcode 0 the new C is the unsigned carry out of the sum. The new V is set when a and b have the same sign and the result's sign differs from it.
- R6: For opcode 1 the new C is set when a + C exceeds b as unsigned values. The new V is set when a and b have different signs and the result's sign differs from b.
- R7: Opcodes 2, 3 and 4 (AND, OR, XOR of a and b) write Z = (result == 0) and N. C and V keep their values.
- R8: Opcodes 5 (arithmetic right) and 6 (logical right) shift a by shamt_i. They write Z, N and C, where C is the last bit shifted out. A zero shift amount leaves C unchanged. V is kept.
- R9: Opcode 7 shifts a left by shamt_i. It writes only Z and N. C and V are kept.
- R10: Flags change only on a clock edge with flag_we_i high. rst_ni low clears all four flags asynchronously. flags_o packs Z in bit 3, N in bit 2, C in bit 1 and V in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation select (codes as in R1, R2, R7, R8, R9) |
| a_i | input | WIDTH | First operand; the subtrahend, and the shift source |
| b_i | input | WIDTH | Second operand; the minuend |
| shamt_i | input | $clog2(WIDTH) | Shift amount |
| flag_we_i | input | 1 | Store the next flags on this edge |
| result_o | output | WIDTH | Combinational result |
| flags_o | output | 4 | Registered flags {Z,N,C,V} |

## Verification
The bench builds the unit with the default WIDTH of 32. With that width the sign-bit boundaries can be hit with literal operands: 0x7fffffff + 1, 0xffffffff + 0xffffffff, and 0x80000000 as a minuend. A shift by the maximum amount of 31 is also reachable. The vector sequence is ordered so that each flag state a row depends on is built up by the rows before it. This covers Z chaining from both a set and a clear Z, a zero shift with C both clear and set, and the preservation of V across bitwise and shift operations.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [2:0] {
    OP_ADC = 3'd0,
    OP_SBB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_ASR = 3'd5,
    OP_LSR = 3'd6,
    OP_SHL = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  flags_t           fl_i,
  output logic [WIDTH-1:0] res_o,
  output flags_t           fl_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] ext;
  logic [WIDTH:0] cin_ext;

  assign cin_ext = {{WIDTH{1'b0}}, fl_i.c};

  always_comb begin
    if (sub_i) ext = {1'b0, b_i} - {1'b0, a_i} - cin_ext;
    else       ext = {1'b0, a_i} + {1'b0, b_i} + cin_ext;
    res_o  = ext[MSB:0];
    fl_o.c = ext[WIDTH];
    // zero chains across words
    fl_o.z = fl_i.z & ~|ext[MSB:0];
    fl_o.n = ext[MSB];
    if (sub_i) fl_o.v = (a_i[MSB] != b_i[MSB]) && (ext[MSB] != b_i[MSB]);
    else       fl_o.v = (a_i[MSB] == b_i[MSB]) && (ext[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  flags_t           fl_i,
  output logic [WIDTH-1:0] res_o,
  output flags_t           fl_o
);
  always_comb begin
    unique case (op_i)
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;
    endcase
    fl_o.z = ~|res_o;
    fl_o.n = res_o[WIDTH-1];
    fl_o.c = fl_i.c;
    fl_o.v = fl_i.v;
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [SHW-1:0]   sh_i,
  input  flags_t           fl_i,
  output logic [WIDTH-1:0] res_o,
  output flags_t           fl_o
);
  logic [WIDTH-1:0] pre_last;  // a shifted by sh-1: bit 0 is the last bit out
  logic [SHW-1:0]   sh_m1;

  assign sh_m1    = sh_i - 1'b1;
  assign pre_last = a_i >> sh_m1;

  always_comb begin
    unique case (op_i)
      OP_ASR:  res_o = WIDTH'($signed(a_i) >>> sh_i);
      OP_LSR:  res_o = a_i >> sh_i;
      default: res_o = a_i << sh_i;
    endcase
    fl_o.z = ~|res_o;
    fl_o.n = res_o[WIDTH-1];
    fl_o.v = fl_i.v;
    if (op_i == OP_SHL || sh_i == '0) fl_o.c = fl_i.c;
    else                              fl_o.c = pre_last[0];
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic             flag_we_i,
  output logic [WIDTH-1:0] result_o,
  output logic [3:0]       flags_o
);
  alu_op_e          op;
  flags_t           cur_fl, nxt_fl;
  flags_t           ar_fl, lg_fl, sh_fl;
  logic [WIDTH-1:0] ar_res, lg_res, sh_res;

  assign op = alu_op_e'(op_i);

  alu_arith #(.WIDTH(WIDTH)) i_arith (
    .sub_i (op == OP_SBB),
    .a_i   (a_i),
    .b_i   (b_i),
    .fl_i  (cur_fl),
    .res_o (ar_res),
    .fl_o  (ar_fl)
  );

  alu_logic #(.WIDTH(WIDTH)) i_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .fl_i  (cur_fl),
    .res_o (lg_res),
    .fl_o  (lg_fl)
  );

  alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) i_shift (
    .op_i  (op),
    .a_i   (a_i),
    .sh_i  (shamt_i),
    .fl_i  (cur_fl),
    .res_o (sh_res),
    .fl_o  (sh_fl)
  );

  always_comb begin
    unique case (op)
      OP_ADC, OP_SBB:         begin result_o = ar_res; nxt_fl = ar_fl; end
      OP_AND, OP_OR, OP_XOR:  begin result_o = lg_res; nxt_fl = lg_fl; end
      default:                begin result_o = sh_res; nxt_fl = sh_fl; end
    endcase
  end

  alu_flag_reg i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we_i),
    .d_i    (nxt_fl),
    .q_o    (cur_fl)
  );

  assign flags_o = cur_fl;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic             flag_we_i,
  input logic [WIDTH-1:0] result_o,
  input logic [3:0]       flags_o
);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  p_n_msb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o[2] == $past(result_o[WIDTH-1]));

  p_z_chain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i <= 3'd1 && !flags_o[3]) |=> !flags_o[3]);

  p_logic_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i >= 3'd2 && op_i <= 3'd4) |=> flags_o[1:0] == $past(flags_o[1:0]));

  p_shr_keep_v_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i == 3'd5 || op_i == 3'd6)) |=> flags_o[0] == $past(flags_o[0]));

  p_shl_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == 3'd7) |=> flags_o[1:0] == $past(flags_o[1:0]));

  p_logic_z_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i >= 3'd2) |=> flags_o[3] == ($past(result_o) == '0));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
  localparam int W = 32;
  localparam int SHW = 5;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [4:0]   sh;
    logic         we;
    logic [W-1:0] res;
    logic [3:0]   fl;   // {Z,N,C,V} after the edge
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 32'h1,        32'h2,        5'd0,  1'b1, 32'h3,        4'b0000},
    '{3'd0, 32'hffffffff, 32'h1,        5'd0,  1'b1, 32'h0,        4'b0010},
    '{3'd0, 32'h0,        32'h0,        5'd0,  1'b1, 32'h1,        4'b0000},
    '{3'd1, 32'h5,        32'h3,        5'd0,  1'b1, 32'hfffffffe, 4'b0110},
    '{3'd1, 32'h1,        32'ha,        5'd0,  1'b1, 32'h8,        4'b0000},
    '{3'd2, 32'hf0f0,     32'h0f0f,     5'd0,  1'b1, 32'h0,        4'b1000},
    '{3'd0, 32'h0,        32'h0,        5'd0,  1'b1, 32'h0,        4'b1000},
    '{3'd0, 32'h7fffffff, 32'h1,        5'd0,  1'b1, 32'h80000000, 4'b0101},
    '{3'd3, 32'h0,        32'h0,        5'd0,  1'b1, 32'h0,        4'b1001},
    '{3'd4, 32'hffffffff, 32'h0,        5'd0,  1'b1, 32'hffffffff, 4'b0101},
    '{3'd6, 32'hf,        32'h0,        5'd1,  1'b1, 32'h7,        4'b0011},
    '{3'd5, 32'h80000000, 32'h0,        5'd4,  1'b1, 32'hf8000000, 4'b0101},
    '{3'd7, 32'h1,        32'h0,        5'd31, 1'b1, 32'h80000000, 4'b0101},
    '{3'd6, 32'h3,        32'h0,        5'd0,  1'b1, 32'h3,        4'b0001},
    '{3'd0, 32'h1,        32'h1,        5'd0,  1'b0, 32'h2,        4'b0001},
    '{3'd1, 32'h0,        32'h0,        5'd0,  1'b1, 32'h0,        4'b0000},
    '{3'd2, 32'h0,        32'h0,        5'd0,  1'b1, 32'h0,        4'b1000},
    '{3'd1, 32'h0,        32'h0,        5'd0,  1'b1, 32'h0,        4'b1000},
    '{3'd0, 32'hffffffff, 32'hffffffff, 5'd0,  1'b1, 32'hfffffffe, 4'b0110},
    '{3'd6, 32'h3,        32'h0,        5'd0,  1'b1, 32'h3,        4'b0010},
    '{3'd1, 32'h0,        32'h0,        5'd0,  1'b1, 32'hffffffff, 4'b0110},
    '{3'd7, 32'h80000000, 32'h0,        5'd1,  1'b1, 32'h0,        4'b1010},
    '{3'd1, 32'h1,        32'h80000000, 5'd0,  1'b1, 32'h7ffffffe, 4'b0001}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     op = '0;
  logic [W-1:0]   a = '0, b = '0;
  logic [SHW-1:0] sh = '0;
  logic           we = 1'b0;
  logic [W-1:0]   res;
  logic [3:0]     fl;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_flag_unit #(.WIDTH(W)) i_alu_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .shamt_i(sh), .flag_we_i(we), .result_o(res), .flags_o(fl)
  );

  function automatic string res_tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd5, 3'd6: return "R8";
      3'd7: return "R9";
      default: return "R7";
    endcase
  endfunction

  function automatic string fl_tag(input logic [2:0] o, input logic w);
    if (!w) return "R10";
    case (o)
      3'd0: return "R3/R5";
      3'd1: return "R3/R6";
      3'd5, 3'd6: return "R8";
      3'd7: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #1;
    check("R10 reset flags", W'(fl), '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 flags after reset", W'(fl), '0);
    for (int i = 0; i < NV; i++) begin
      op = TBL[i].op; a = TBL[i].a; b = TBL[i].b; sh = TBL[i].sh; we = TBL[i].we;
      #1;
      check(res_tag(TBL[i].op), res, TBL[i].res);
      @(negedge clk);
      check(fl_tag(TBL[i].op, TBL[i].we), W'(fl), W'(TBL[i].fl));
      if (TBL[i].we) check("R4 N flag", W'(fl[2]), W'(TBL[i].res[W-1]));
    end
    // R10: asynchronous reset from a non-zero flag state
    we = 1'b0;
    #1 rst_n = 1'b0;
    #1 check("R10 async clear", W'(fl), '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: longest logical shift, last bit out is bit 30
    op = 3'd6; a = 32'h40000000; sh = 5'd31; we = 1'b1;
    #1 check("R8 lsr 31", res, 32'h0);
    @(negedge clk);
    check("R8 lsr 31 flags", W'(fl), W'(4'b1010));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule